// File: doc/BRIEF.md
# Interleaved Multicycle Compute Unit

This block wraps a slow arithmetic element so that the stream rate is one operand per clock, while each copy of the element gets a full window of `WAYS` clocks to settle. The element (a squaring unit with a constant offset) is instantiated `WAYS` times. A rotating lane pointer hands each accepted operand to the next copy in turn. That copy's input register loads only on its own turn and holds its operand stable until the result is taken. A tag delay line carries the lane index and a valid bit forward. After exactly `WAYS` clocks the tag steers an output multiplexer to the matching copy, and the result goes into an output register. Results therefore leave in the order the operands arrived.

The control is a small rotation state: the lane pointer has the named values LANE_0 to LANE_(WAYS-1). It has two transitions. ADVANCE happens on any cycle with `in_valid` high and moves the pointer to the next lane, wrapping after the last one. HOLD happens on any cycle with `in_valid` low and keeps the pointer where it is. Reset forces LANE_0 and clears every valid bit, so results still in flight are discarded.

Top module: `interleave_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `out_valid` and `out_data` to 0, returns the lane pointer to lane 0, and discards every operand still in flight: none of them ever produces `out_valid`.
- R2: Each result equals the low `DATA_W` bits of x*x + 5, where x is the accepted operand. This holds at the edge values 0, all ones and the top bit alone.
- R3: `out_valid` is high in exactly the cycle that lies `WAYS` clock edges after the edge that accepted the matching operand. It is high in no other cycle.
- R4: Operands presented on every consecutive clock are all accepted. Their results appear on consecutive clocks, in arrival order.
- R5: A cycle with `in_valid` low does not move the lane pointer. Gaps in the input stream produce matching gaps in `out_valid` and do not reorder results.
- R6: Operands go to lanes 0, 1, ... `WAYS`-1 in turn, then wrap. A lane register loads only on its own turn and otherwise holds its value. As a result, alternating operand streams, with or without gaps, all return correct results.
- R7: While `out_valid` is low, `out_data` keeps the last result presented (0 after reset).
- R8: `in_data` is ignored on cycles with `in_valid` low. Data present during gaps has no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | DATA_W | Operand |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | DATA_W | Result, held while out_valid is low |

## Verification
The first pattern is a back-to-back stream. It loads every lane on every rotation, so a copy that is overwritten early or a multiplexer that picks the wrong lane shows up as a wrong value. Next come gapped streams with junk data placed in the holes. They separate a pointer that advances on idle cycles, and a lane that loads junk, from a correct design, because either fault reorders or corrupts later results. A stream with alternating one-cycle gaps, followed by the extreme operand values, exercises the lane wrap and the full-width product. A reset in the middle of the stream, with operands in flight, checks that no stale result appears and that a fresh stream then runs correctly.

// File: rtl/il_pkg.sv
package il_pkg;

    // Constant added to the square inside every compute lane.
    localparam int unsigned RES_OFFSET = 5;

    // Width of a lane index for a given number of lanes.
    function automatic int unsigned sel_bits(int unsigned ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/il_rotator.sv
module il_rotator #(
    parameter int unsigned WAYS = 2,
    parameter int unsigned SW   = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    output logic [SW-1:0]   sel,
    output logic [WAYS-1:0] load_vec
);
    localparam logic [SW-1:0] LAST = SW'(WAYS - 1);

    // Lane pointer: ADVANCE when an operand arrives, HOLD otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (advance) begin
            sel <= (sel == LAST) ? '0 : sel + 1'b1;
        end
    end

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            load_vec[i] = advance && (sel == SW'(i));
        end
    end

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (advance && sel == LAST) |=> (sel == '0));

    assert_gap_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(sel));

    assert_range_R6: assert property (@(posedge clk) disable iff (rst)
        sel <= LAST);

    assert_one_load_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));

endmodule

// File: rtl/il_lane.sv
module il_lane #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] op_in,
    output logic              op_v,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] op_q;

    // Enabled input register: written only on this lane's turn.
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
            op_v <= 1'b0;
        end else if (load) begin
            op_q <= op_in;
            op_v <= 1'b1;
        end
    end

    // Slow element: a multicycle path sampled WAYS edges after loading.
    assign result = op_q * op_q + DATA_W'(il_pkg::RES_OFFSET);

    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(op_q));

    assert_lane_valid_R1: assert property (@(posedge clk) disable iff (rst)
        load |=> op_v);

endmodule

// File: rtl/il_tag_pipe.sv
module il_tag_pipe #(
    parameter int unsigned WAYS = 2,
    parameter int unsigned SW   = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_v,
    input  logic [SW-1:0] in_sel,
    output logic          out_v,
    output logic [SW-1:0] out_sel
);
    logic          v_q   [WAYS];
    logic [SW-1:0] sel_q [WAYS];

    // Stage 0 pairs with the lane register; stages 1..WAYS-1 are the
    // extra alignment registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            v_q[0]   <= 1'b0;
            sel_q[0] <= '0;
        end else begin
            v_q[0]   <= in_v;
            sel_q[0] <= in_sel;
        end
    end

    for (genvar k = 1; k < WAYS; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q[k]   <= 1'b0;
                sel_q[k] <= '0;
            end else begin
                v_q[k]   <= v_q[k-1];
                sel_q[k] <= sel_q[k-1];
            end
        end
    end

    assign out_v   = v_q[WAYS-1];
    assign out_sel = sel_q[WAYS-1];

    assert_tag_first_R3: assert property (@(posedge clk) disable iff (rst)
        in_v |=> v_q[0]);

endmodule

// File: rtl/interleave_unit.sv
module interleave_unit #(
    parameter int unsigned WAYS   = 2,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int unsigned SW = il_pkg::sel_bits(WAYS);

    logic [SW-1:0]     sel;
    logic [WAYS-1:0]   load_vec;
    logic [WAYS-1:0]   lane_v;
    logic [DATA_W-1:0] lane_res [WAYS];
    logic              tag_v;
    logic [SW-1:0]     tag_sel;
    logic              pick_v;
    logic [DATA_W-1:0] pick_res;

    il_rotator #(.WAYS(WAYS), .SW(SW)) u_rot (
        .clk      (clk),
        .rst      (rst),
        .advance  (in_valid),
        .sel      (sel),
        .load_vec (load_vec)
    );

    for (genvar i = 0; i < WAYS; i++) begin : g_lane
        il_lane #(.DATA_W(DATA_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .load   (load_vec[i]),
            .op_in  (in_data),
            .op_v   (lane_v[i]),
            .result (lane_res[i])
        );
    end

    il_tag_pipe #(.WAYS(WAYS), .SW(SW)) u_tag (
        .clk     (clk),
        .rst     (rst),
        .in_v    (in_valid),
        .in_sel  (sel),
        .out_v   (tag_v),
        .out_sel (tag_sel)
    );

    // Output multiplexer steered by the delayed lane index.
    always_comb begin
        pick_v   = 1'b0;
        pick_res = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (tag_sel == SW'(i)) begin
                pick_v   = tag_v && lane_v[i];
                pick_res = lane_res[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pick_v;
            if (pick_v) begin
                out_data <= pick_res;
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && out_data == '0));

    assert_out_from_tag_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(tag_v));

    assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

// File: tb/interleave_unit_test.sv
module interleave_unit_test;
    localparam int WAYS = 2;
    localparam int DW   = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;

    interleave_unit #(.WAYS(WAYS), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int            q_due [$];
    logic [DW-1:0] q_val [$];
    string         q_req [$];
    int            n_checks = 0;
    int            n_fail = 0;
    logic [DW-1:0] last_out = '0;
    bit            mon_on = 1'b0;
    bit            done = 1'b0;

    function automatic logic [DW-1:0] ref_fn(logic [DW-1:0] x);
        logic [31:0] p;
        p = {16'd0, x} * {16'd0, x} + 32'd5;
        return p[DW-1:0];
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [DW-1:0] v, string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        q_due.push_back(cyc + 1 + WAYS);
        q_val.push_back(ref_fn(v));
        q_req.push_back(req);
    endtask

    task automatic idle(int n, logic [DW-1:0] junk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = junk;
        end
    endtask

    // Monitor: pop expected results as the design produces them.
    always @(negedge clk) begin
        if (mon_on) begin
            if (rst) begin
                last_out = '0;
            end else if (out_valid) begin
                if (q_due.size() == 0) begin
                    check(1'b0, "R3", "unexpected out_valid", 1, 0);
                end else begin
                    check(q_due[0] == cyc, "R3", "result cycle", cyc, q_due[0]);
                    check(out_data == q_val[0], q_req[0], "result value",
                          int'(out_data), int'(q_val[0]));
                    void'(q_due.pop_front());
                    void'(q_val.pop_front());
                    void'(q_req.pop_front());
                end
                last_out = out_data;
            end else begin
                check(out_data == last_out, "R7", "held data",
                      int'(out_data), int'(last_out));
                if (q_due.size() > 0 && q_due[0] <= cyc) begin
                    check(1'b0, "R3", "missing out_valid", 0, 1);
                    void'(q_due.pop_front());
                    void'(q_val.pop_front());
                    void'(q_req.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(out_data == '0, "R1", "out_data in reset", int'(out_data), 0);
        rst = 1'b0;
        mon_on = 1'b1;
        idle(2, 16'h1111);

        // R4: back-to-back stream
        for (int i = 0; i < 24; i++) send(16'(i * 37 + 1), "R4");
        idle(WAYS + 2, 16'h2222);

        // R5 / R8: gapped stream with junk data in the holes
        for (int i = 0; i < 30; i++) begin
            if (i % 3 == 1) idle(1, 16'hDEAD ^ 16'(i));
            else send(16'(i * 1013 + 7), (i % 2 == 0) ? "R5" : "R8");
        end
        idle(WAYS + 2, 16'h3333);

        // R6: alternating single-cycle gaps across the lane wrap
        for (int i = 0; i < 12; i++) begin
            send(16'(i * 4099 + 3), "R6");
            if (i % 2 == 1) idle(1, 16'hBEEF);
        end

        // R2: extreme operand values
        send(16'h0000, "R2");
        send(16'hFFFF, "R2");
        send(16'h8000, "R2");
        send(16'h0001, "R2");
        idle(WAYS + 3, 16'h4444);

        // R1: reset with operands in flight; none may emerge
        send(16'h1234, "R1");
        send(16'h5678, "R1");
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        q_due.delete();
        q_val.delete();
        q_req.delete();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle(WAYS + 3, 16'h5555);
        check(out_valid == 1'b0, "R1", "no stale result", int'(out_valid), 0);
        check(out_data == '0, "R1", "data after reset", int'(out_data), 0);
        for (int i = 0; i < 8; i++) send(16'(i * 211 + 9), "R1");

        // drain
        idle(1, 16'h6666);
        for (int i = 0; i < 50 && q_due.size() > 0; i++) idle(1, 16'h6666);
        check(q_due.size() == 0, "R3", "queue drained", q_due.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule